// File: doc/BRIEF.md
# Half-Duplex Transmit Status Monitor

This block sits beside the transmit engine of an Ethernet MAC and keeps three sticky status flags that record the typical failure cases of CSMA/CD transmission. The first is an abort after too many back-to-back collisions on one frame. The second is carrier sense that was absent when a frame began, or that dropped while the frame was going out. The third is a frame that stayed in deferral longer than a speed-dependent limit. The transmit engine supplies one-cycle strobes for frame start, frame end and collision, and a level that is high while it defers. The block also samples the carrier-sense line directly.

A small write port serves two registers. With `wr_sel` low, each 1 in `wr_data` clears the matching status flag. With `wr_sel` high, `wr_data` replaces the enable register. The flags that are both set and enabled are ORed onto a single interrupt line. When the collision limit is reached, the block also sends the transmit engine a one-cycle abort request. Every check is gated by the duplex bit, and the deferral check is also gated by a no-defer control bit.

Top module: `hdx_tx_status`

## Requirements
- R1: After reset, `status`, `enable`, `tx_irq` and `abort_req` are all zero.
- R2: When a collision strobe is the 16th consecutive collision of a frame, `status[0]` (abort) and `abort_req` are high from the following cycle. `abort_req` lasts exactly one cycle. After 15 collisions, neither signal is raised.
- R3: The consecutive-collision count restarts from zero on `tx_start`, on `tx_end` and on an abort.
- R4: If `crs` is low in the cycle of `tx_start`, `status[1]` (no carrier) is set from the next cycle.
- R5: If `crs` is low in any cycle between `tx_start` and the end of the frame (`tx_end` or abort), `status[1]` is set. A low `crs` outside a frame sets nothing.
- R6: `status[2]` (defer exceeded) is set after `tx_deferring` has been high for more than LIMIT cycles. LIMIT is `DEFER_LIMIT_FAST` when `speed_fast`=1 and `DEFER_LIMIT_SLOW` otherwise. The flag is raised at most once per deferral episode, and the cycle count restarts whenever `tx_deferring` drops.
- R7: While `no_defer`=1, deferral never sets `status[2]`.
- R8: While `full_duplex`=1, no event sets any status flag and `abort_req` stays low.
- R9: A write with `wr_sel`=0 clears each status bit where `wr_data` holds 1. Bits where `wr_data` holds 0 keep their value.
- R10: If a set event and a clear write hit the same status bit in the same cycle, the bit ends up set.
- R11: A write with `wr_sel`=1 loads `enable`. `tx_irq` is high exactly when some bit is set in both `status` and `enable`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| full_duplex | input | 1 | 1 = full duplex; all checks disabled |
| no_defer | input | 1 | 1 = skip the deferral time check |
| speed_fast | input | 1 | 1 = 100 Mbps limit, 0 = 10 Mbps limit |
| tx_start | input | 1 | Strobe: a new frame begins |
| tx_end | input | 1 | Strobe: frame completed successfully |
| tx_coll | input | 1 | Strobe: a collision occurred |
| tx_deferring | input | 1 | Level: frame is waiting in deferral |
| crs | input | 1 | Carrier sense from the PHY |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = clear status bits, 1 = load enables |
| wr_data | input | 3 | Write data; bit 0 abort, bit 1 no carrier, bit 2 defer |
| status | output | 3 | Sticky flags; bit 0 abort, bit 1 no carrier, bit 2 defer |
| enable | output | 3 | Interrupt enable register |
| tx_irq | output | 1 | Transmit interrupt |
| abort_req | output | 1 | One-cycle request to abandon the current frame |

## Verification
The bench targets the off-by-one edges of both counters. It checks that 15 collisions and exactly LIMIT deferral cycles raise nothing, while one more does. A counter compared against the wrong value would move the flag a cycle early or late. It also checks that the collision count restarts at frame boundaries and that the deferral count restarts when an episode is broken. A design that kept counting across these points would abort or flag spuriously. Further tests drive a set and a clear into the same bit in one cycle, write zeros over a set flag, drop carrier outside a frame, and run every failure case in full duplex. A wrong priority, a non-sticky flag or missing gating each shows up directly on `status`.

// File: rtl/hdx_status_pkg.sv
`timescale 1ns/1ps
package hdx_status_pkg;
  localparam int NFLAG   = 3;
  localparam int F_ABORT = 0;
  localparam int F_NOCRS = 1;
  localparam int F_DEFER = 2;

  // sticky update: clear first, then set, so a same-cycle event survives
  function automatic logic [NFLAG-1:0] next_flags(input logic [NFLAG-1:0] cur,
                                                  input logic [NFLAG-1:0] set,
                                                  input logic [NFLAG-1:0] clr);
    return (cur & ~clr) | set;
  endfunction

  function automatic int pick_limit(input logic fast, input int lim_fast, input int lim_slow);
    return fast ? lim_fast : lim_slow;
  endfunction
endpackage

// File: rtl/hdx_coll_track.sv
`timescale 1ns/1ps
module hdx_coll_track #(
  parameter int COLL_LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_dup,
  input  logic tx_start,
  input  logic tx_end,
  input  logic tx_coll,
  output logic abort_evt,
  output logic abort_req
);
  localparam int CW = $clog2(COLL_LIMIT);
  localparam logic [CW-1:0] LAST = CW'(COLL_LIMIT - 1);

  logic [CW-1:0] cnt;

  assign abort_evt = half_dup && tx_coll && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      abort_req <= 1'b0;
    end else begin
      abort_req <= abort_evt;
      if (tx_start || tx_end || abort_evt) cnt <= '0;
      else if (half_dup && tx_coll)        cnt <= cnt + 1'b1;
    end
  end

  p_abort_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |=> !abort_req);
  p_cnt_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_start || tx_end) |=> (cnt == '0));
endmodule

// File: rtl/hdx_crs_check.sv
`timescale 1ns/1ps
module hdx_crs_check (
  input  logic clk,
  input  logic rst_n,
  input  logic half_dup,
  input  logic tx_start,
  input  logic tx_end,
  input  logic abort_evt,
  input  logic crs,
  output logic nocrs_evt,
  output logic in_frame
);
  always_ff @(posedge clk) begin
    if (!rst_n)                    in_frame <= 1'b0;
    else if (tx_start)             in_frame <= 1'b1;
    else if (tx_end || abort_evt)  in_frame <= 1'b0;
  end

  assign nocrs_evt = half_dup && !crs && (tx_start || in_frame);

  p_frame_open_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> in_frame);
  p_frame_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_start && (tx_end || abort_evt)) |=> !in_frame);
endmodule

// File: rtl/hdx_defer_timer.sv
`timescale 1ns/1ps
module hdx_defer_timer
  import hdx_status_pkg::*;
#(
  parameter int LIMIT_FAST = 8192,
  parameter int LIMIT_SLOW = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic half_dup,
  input  logic no_defer,
  input  logic speed_fast,
  input  logic deferring,
  output logic defer_evt
);
  localparam int MAXL = (LIMIT_FAST > LIMIT_SLOW) ? LIMIT_FAST : LIMIT_SLOW;
  localparam int CW   = $clog2(MAXL + 2);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          active;

  assign lim       = CW'(pick_limit(speed_fast, LIMIT_FAST, LIMIT_SLOW));
  assign active    = half_dup && !no_defer && deferring;
  assign defer_evt = active && (cnt == lim);

  // saturates at lim+1 so the trip fires once per episode
  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (!active)    cnt <= '0;
    else if (cnt <= lim) cnt <= cnt + 1'b1;
  end

  p_defer_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    defer_evt |=> !defer_evt);
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !deferring |=> (cnt == '0));
  p_nodef_r7: assert property (@(posedge clk) disable iff (!rst_n)
    no_defer |-> !defer_evt);
endmodule

// File: rtl/hdx_flag_bank.sv
`timescale 1ns/1ps
module hdx_flag_bank
  import hdx_status_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] set_vec,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [NFLAG-1:0] wr_data,
  output logic [NFLAG-1:0] status,
  output logic [NFLAG-1:0] enable
);
  logic [NFLAG-1:0] clr_vec;

  assign clr_vec = (wr_en && !wr_sel) ? wr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= '0;
      enable <= '0;
    end else begin
      status <= next_flags(status, set_vec, clr_vec);
      if (wr_en && wr_sel) enable <= wr_data;
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_chk
    p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> status[i]);
    p_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec[i] && !set_vec[i]) |=> !status[i]);
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !clr_vec[i]) |=> status[i]);
  end
endmodule

// File: rtl/hdx_tx_status.sv
`timescale 1ns/1ps
module hdx_tx_status
  import hdx_status_pkg::*;
#(
  parameter int COLL_LIMIT       = 16,
  parameter int DEFER_LIMIT_FAST = 8192,
  parameter int DEFER_LIMIT_SLOW = 8192
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             full_duplex,
  input  logic             no_defer,
  input  logic             speed_fast,
  input  logic             tx_start,
  input  logic             tx_end,
  input  logic             tx_coll,
  input  logic             tx_deferring,
  input  logic             crs,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [NFLAG-1:0] wr_data,
  output logic [NFLAG-1:0] status,
  output logic [NFLAG-1:0] enable,
  output logic             tx_irq,
  output logic             abort_req
);
  logic             half_dup;
  logic             abort_evt;
  logic             nocrs_evt;
  logic             defer_evt;
  logic             in_frame;
  logic [NFLAG-1:0] set_vec;

  assign half_dup = !full_duplex;

  hdx_coll_track #(.COLL_LIMIT(COLL_LIMIT)) u_coll (
    .clk(clk), .rst_n(rst_n), .half_dup(half_dup), .tx_start(tx_start),
    .tx_end(tx_end), .tx_coll(tx_coll), .abort_evt(abort_evt), .abort_req(abort_req));

  hdx_crs_check u_crs (
    .clk(clk), .rst_n(rst_n), .half_dup(half_dup), .tx_start(tx_start),
    .tx_end(tx_end), .abort_evt(abort_evt), .crs(crs),
    .nocrs_evt(nocrs_evt), .in_frame(in_frame));

  hdx_defer_timer #(.LIMIT_FAST(DEFER_LIMIT_FAST), .LIMIT_SLOW(DEFER_LIMIT_SLOW)) u_defer (
    .clk(clk), .rst_n(rst_n), .half_dup(half_dup), .no_defer(no_defer),
    .speed_fast(speed_fast), .deferring(tx_deferring), .defer_evt(defer_evt));

  always_comb begin
    set_vec          = '0;
    set_vec[F_ABORT] = abort_evt;
    set_vec[F_NOCRS] = nocrs_evt;
    set_vec[F_DEFER] = defer_evt;
  end

  hdx_flag_bank u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .status(status), .enable(enable));

  assign tx_irq = |(status & enable);

  p_fd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full_duplex |-> (set_vec == '0));
  p_abort_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    abort_req |-> status[F_ABORT]);
  p_irq_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !tx_irq);
  p_idle_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_frame && !tx_start) |-> !nocrs_evt);
endmodule

// File: tb/sim_hdx_tx_status.sv
`timescale 1ns/1ps
module sim_hdx_tx_status;
  localparam int LF = 64;
  localparam int LS = 160;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic full_duplex = 0, no_defer = 0, speed_fast = 1;
  logic tx_start = 0, tx_end = 0, tx_coll = 0, tx_deferring = 0, crs = 1;
  logic wr_en = 0, wr_sel = 0;
  logic [2:0] wr_data = '0;
  logic [2:0] status, enable;
  logic tx_irq, abort_req;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hdx_tx_status #(.COLL_LIMIT(16), .DEFER_LIMIT_FAST(LF), .DEFER_LIMIT_SLOW(LS)) u0 (
    .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .no_defer(no_defer),
    .speed_fast(speed_fast), .tx_start(tx_start), .tx_end(tx_end), .tx_coll(tx_coll),
    .tx_deferring(tx_deferring), .crs(crs), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .status(status), .enable(enable), .tx_irq(tx_irq),
    .abort_req(abort_req));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [2:0] d);
    wr_en = 1; wr_sel = sel; wr_data = d; tick(1);
    wr_en = 0; wr_data = '0;
  endtask

  task automatic start_frame;
    tx_start = 1; tick(1); tx_start = 0;
  endtask

  task automatic end_frame;
    tx_end = 1; tick(1); tx_end = 0;
  endtask

  task automatic collide(input int n);
    for (int i = 0; i < n; i++) begin tx_coll = 1; tick(1); end
    tx_coll = 0;
  endtask

  task automatic t_reset;
    chk("R1 status", status, 0);
    chk("R1 enable", enable, 0);
    chk("R1 irq", tx_irq, 0);
    chk("R1 abort_req", abort_req, 0);
  endtask

  task automatic t_abort;
    wr(1, 3'b111);
    chk("R11 enable load", enable, 3'b111);
    start_frame();
    collide(15);
    chk("R2 no abort at 15", status[0], 0);
    chk("R2 no req at 15", abort_req, 0);
    collide(1);
    chk("R2 abort flag", status[0], 1);
    chk("R2 abort_req", abort_req, 1);
    chk("R11 irq on abort", tx_irq, 1);
    tick(1);
    chk("R2 req one cycle", abort_req, 0);
    wr(0, 3'b001);
    chk("R9 w1c abort", status, 0);
    chk("R11 irq drops", tx_irq, 0);
  endtask

  task automatic t_coll_restart;
    start_frame(); collide(15); start_frame(); collide(1);
    chk("R3 restart on start", status[0], 0);
    collide(9); end_frame(); collide(10);
    chk("R3 restart on end", status[0], 0);
    end_frame();
  endtask

  task automatic t_crs_start;
    crs = 0; tx_start = 1; tick(1); tx_start = 0;
    crs = 1;
    chk("R4 no carrier at start", status[1], 1);
    end_frame();
    wr(0, 3'b010);
    chk("R9 clear nocrs", status[1], 0);
  endtask

  task automatic t_crs_mid;
    crs = 0; tick(4); crs = 1;
    chk("R5 idle low crs ignored", status[1], 0);
    start_frame(); tick(3);
    chk("R5 carrier held", status[1], 0);
    crs = 0; tick(1);
    chk("R5 carrier drop mid-frame", status[1], 1);
    wr(0, 3'b000);
    chk("R9 write zero keeps", status[1], 1);
    wr(0, 3'b010);
    chk("R10 set beats clear", status[1], 1);
    crs = 1; wr(0, 3'b010);
    chk("R9 clear after carrier", status[1], 0);
    end_frame();
  endtask

  task automatic t_defer;
    speed_fast = 1; tx_deferring = 1; tick(LF);
    chk("R6 fast at limit", status[2], 0);
    tick(1);
    chk("R6 fast past limit", status[2], 1);
    wr(0, 3'b100); tick(LF + 10);
    chk("R6 once per episode", status[2], 0);
    tx_deferring = 0; tick(1);
    tx_deferring = 1; tick(LF - 4); tx_deferring = 0; tick(1);
    tx_deferring = 1; tick(LF - 4);
    chk("R6 count restarts", status[2], 0);
    tx_deferring = 0; tick(1);
    speed_fast = 0; tx_deferring = 1; tick(LS);
    chk("R6 slow at limit", status[2], 0);
    tick(1);
    chk("R6 slow past limit", status[2], 1);
    tx_deferring = 0; wr(0, 3'b100);
    speed_fast = 1;
  endtask

  task automatic t_nodefer;
    no_defer = 1; tx_deferring = 1; tick(3 * LF);
    chk("R7 no-defer suppresses", status[2], 0);
    tx_deferring = 0; no_defer = 0; tick(1);
  endtask

  task automatic t_full_duplex;
    full_duplex = 1;
    crs = 0; start_frame(); collide(20);
    chk("R8 no abort_req", abort_req, 0);
    tx_deferring = 1; tick(LS + 5); tx_deferring = 0;
    end_frame(); crs = 1;
    chk("R8 no flags", status, 0);
    full_duplex = 0; tick(1);
  endtask

  task automatic t_irq_mask;
    wr(1, 3'b000);
    crs = 0; start_frame(); crs = 1; end_frame();
    chk("R11 masked flag", tx_irq, 0);
    wr(1, 3'b010);
    chk("R11 enabled flag", tx_irq, 1);
    wr(1, 3'b101);
    chk("R11 other enables", tx_irq, 0);
    wr(0, 3'b111);
  endtask

  initial begin
    tick(3);
    t_reset();
    rst_n = 1; tick(1);
    t_reset();
    t_abort();
    t_coll_restart();
    t_crs_start();
    t_crs_mid();
    t_defer();
    t_nodefer();
    t_full_duplex();
    t_irq_mask();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule